// File: doc/BRIEF.md
# Byte-Wide 64-bit Cyclic Redundancy Code Engine

This block folds a byte stream into a 64-bit cyclic redundancy code, one byte per clock. Bytes arrive on a valid/ready stream that carries start-of-message and end-of-message flags. Each accepted byte advances the remainder register by a full byte. The advance uses a 256-entry lookup table that is computed at elaboration time from the generator x^64 + x^63 + x^2 + 1. That generator is (x+1) times a primitive trinomial of degree 63. The register shifts right, so every byte is consumed least-significant bit first.

The engine serves two roles, chosen per message by a check flag.

- **Encode:** the sender reads the remainder when the message ends and appends it to the message.
- **Check:** the receiver passes the message and the appended remainder through the engine. It then sees a pass flag when the final remainder is zero.

A start flag on a byte reseeds the register to zero before that byte is absorbed, so messages can follow each other with no idle cycle between them. A synchronous clear input also reseeds the register at any time.

Top module: `crc64_engine`

## Requirements
- R1: While reset is asserted and right after it, `crc_out` is zero and both `crc_valid` and `crc_ok` are low. Once reset is released and `clr` is low, `in_ready` is high.
- R2: In encode mode, `crc_out` is the remainder of the message under the reflected generator constant 0xA000000000000001, with a zero seed and no final inversion. Bits are taken least-significant first within each byte.
- R3: `crc_valid` is high for exactly the one cycle after the clock edge that accepts a byte flagged end-of-message, and is low otherwise.
- R4: A byte flagged start-of-message is absorbed into a zero register, whatever came before. Two messages sent back to back without an idle cycle each give their own independent remainder.
- R5: In check mode, a message followed by its 8-byte remainder, lowest byte first, gives `crc_ok` = 1 together with `crc_valid`.
- R6: In check mode, flipping any odd number of bits in a message or in its appended remainder gives `crc_ok` = 0.
- R7: `crc_ok` is high only while `crc_valid` is high, and stays low for a message whose end-of-message byte is presented with `in_check` = 0.
- R8: While `clr` is high, `in_ready` is low and any presented byte is not absorbed. On the next cycle `crc_out` is zero, and absorption resumes from zero after that.
- R9: Cycles without an accepted byte leave `crc_out` unchanged, so gaps inside a message do not alter the remainder. The data presented during those cycles has no effect.
- R10: The mode of a message is taken from `in_check` on its end-of-message byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous reseed of the remainder to zero |
| in_valid | input | 1 | Byte present |
| in_ready | output | 1 | Byte can be accepted (low during clear) |
| in_data | input | 8 | Message byte |
| in_sop | input | 1 | First byte of a message |
| in_eop | input | 1 | Last byte of a message |
| in_check | input | 1 | 1 = check mode, 0 = encode mode (sampled with the last byte) |
| crc_out | output | 64 | Current remainder register |
| crc_valid | output | 1 | One-cycle pulse after the last byte is absorbed |
| crc_ok | output | 1 | Zero remainder in check mode, qualified by crc_valid |

## Verification
Encode results are compared against a bit-serial shift model of the same reflected generator. The inputs are all-zero bytes, all-ones bytes, an incrementing ramp, a single high-bit byte and a pseudo-random stream. Together these separate a wrong table entry, a wrong shift direction and a wrong bit order within a byte. Check mode is run on intact codewords and on codewords with one and three flipped bits, which separates a true zero test from a flag that is stuck at one. Back-to-back messages, mid-message gaps with changing idle data, a clear pulse in the middle of a message and a mode change on the final byte tell the reseed, hold and mode-sampling paths apart.

// File: rtl/crc64_pkg.sv
package crc64_pkg;
  localparam int CRC_W  = 64;
  localparam int BYTE_W = 8;
  localparam int LUT_N  = 2 ** BYTE_W;

  typedef logic [CRC_W-1:0]  crc_t;
  typedef logic [BYTE_W-1:0] byte_t;

  // generator without the x^64 term: x^63 + x^2 + 1
  localparam crc_t GEN_NORMAL = 64'h8000_0000_0000_0005;

  function automatic crc_t bit_reverse(input crc_t v);
    crc_t r;
    for (int i = 0; i < CRC_W; i++) r[i] = v[CRC_W-1-i];
    return r;
  endfunction

  localparam crc_t GEN_REFL = bit_reverse(GEN_NORMAL);

  // remainder of one byte value pushed through eight right shifts
  function automatic crc_t lut_entry(input crc_t prefl, input int unsigned idx);
    crc_t r;
    r = crc_t'(idx);
    for (int b = 0; b < BYTE_W; b++) r = r[0] ? ((r >> 1) ^ prefl) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/crc64_lut.sv
module crc64_lut
  import crc64_pkg::*;
#(
  parameter crc_t POLY_REFL = GEN_REFL
) (
  input  byte_t idx,
  output crc_t  entry
);
  crc_t tbl [LUT_N];

  for (genvar g = 0; g < LUT_N; g++) begin : g_ent
    localparam crc_t VAL = lut_entry(POLY_REFL, g);
    assign tbl[g] = VAL;
  end

  assign entry = tbl[idx];
endmodule

// File: rtl/crc64_step.sv
module crc64_step
  import crc64_pkg::*;
#(
  parameter crc_t POLY_REFL = GEN_REFL
) (
  input  crc_t  crc_in,
  input  byte_t data_in,
  output crc_t  crc_nxt
);
  byte_t idx;
  crc_t  entry;

  assign idx = crc_in[BYTE_W-1:0] ^ data_in;

  crc64_lut #(.POLY_REFL(POLY_REFL)) u_lut (
    .idx   (idx),
    .entry (entry)
  );

  assign crc_nxt = (crc_in >> BYTE_W) ^ entry;
endmodule

// File: rtl/crc64_engine.sv
module crc64_engine
  import crc64_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic              in_check,
  output logic [CRC_W-1:0]  crc_out,
  output logic              crc_valid,
  output logic              crc_ok
);
  crc_t crc_q, crc_d, crc_base, crc_stepped;
  logic done_q, done_d;
  logic chk_q, chk_d;
  logic accept, crc_en;

  assign in_ready = ~clr;
  assign accept   = in_valid & in_ready;
  assign crc_en   = clr | accept;
  assign crc_base = in_sop ? '0 : crc_q;

  crc64_step #(.POLY_REFL(GEN_REFL)) u_step (
    .crc_in  (crc_base),
    .data_in (in_data),
    .crc_nxt (crc_stepped)
  );

  always_comb begin
    crc_d  = crc_q;
    done_d = 1'b0;
    chk_d  = chk_q;
    if (clr) begin
      crc_d = '0;
    end else if (accept) begin
      crc_d  = crc_stepped;
      done_d = in_eop;
      if (in_eop) chk_d = in_check;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q  <= '0;
      done_q <= 1'b0;
      chk_q  <= 1'b0;
    end else begin
      if (crc_en) crc_q <= crc_d;
      done_q <= done_d;
      if (accept) chk_q <= chk_d;
    end
  end

  assign crc_out   = crc_q;
  assign crc_valid = done_q;
  assign crc_ok    = done_q & chk_q & (crc_q == '0);

  AST_VALID_AFTER_EOP: assert property (@(posedge clk) disable iff (!rst_n)
    crc_valid |-> $past(in_valid && in_ready && in_eop)); // R3
  AST_EOP_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_eop) |=> crc_valid); // R3
  AST_OK_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    crc_ok |-> crc_valid); // R7
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (crc_out == '0)); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !clr) |=> $stable(crc_out)); // R9
endmodule

// File: tb/crc64_engine_test.sv
module crc64_engine_test;
  logic        clk = 1'b0;
  logic        rst_n, clr, in_valid, in_sop, in_eop, in_check, in_ready;
  logic [7:0]  in_data;
  logic [63:0] crc_out;
  logic        crc_valid, crc_ok;

  int n_vec = 0, n_bad = 0;
  logic [7:0] buf_a [0:63];
  bit   hold_err;

  always #5 clk = ~clk;

  crc64_engine uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .in_check(in_check),
    .crc_out(crc_out), .crc_valid(crc_valid), .crc_ok(crc_ok)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bit-serial reference, reflected generator 0xA000000000000001
  function automatic logic [63:0] ref_crc(input int start, input int len);
    logic [63:0] c = '0;
    for (int i = start; i < start + len; i++)
      for (int b = 0; b < 8; b++) begin
        logic fb;
        fb = c[0] ^ buf_a[i][b];
        c  = c >> 1;
        if (fb) c = c ^ 64'hA000_0000_0000_0001;
      end
    return c;
  endfunction

  task automatic append_crc(input int len);
    logic [63:0] c;
    c = ref_crc(0, len);
    for (int k = 0; k < 8; k++) buf_a[len+k] = c[8*k +: 8];
  endtask

  task automatic run_msg(input int start, input int len, input bit first_sop, input bit chk,
                         input bit eop_chk, input int gap,
                         output logic [63:0] got, output logic got_v, output logic got_ok,
                         output logic after_v);
    logic [63:0] held;
    hold_err = 1'b0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = buf_a[start+i];
      in_sop = first_sop && (i == 0); in_eop = (i == len-1);
      in_check = (i == len-1) ? eop_chk : chk;
      if (gap > 0 && i < len-1) begin
        @(negedge clk);
        in_valid = 1'b0; in_data = ~in_data; in_sop = 1'b1;
        held = crc_out;
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          in_data = in_data + 8'h3B;
          if (crc_out !== held) hold_err = 1'b1;
        end
        in_sop = 1'b0;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    got = crc_out; got_v = crc_valid; got_ok = crc_ok;
    @(negedge clk);
    after_v = crc_valid;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; clr = 1'b0; in_valid = 1'b0; in_data = '0;
    in_sop = 1'b0; in_eop = 1'b0; in_check = 1'b0;
    repeat (3) @(negedge clk);
    check(crc_out == 0 && !crc_valid && !crc_ok, "R1 reset outputs", {62'd0, crc_valid, crc_ok} | crc_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(crc_out == 0 && !crc_valid && !crc_ok, "R1 after release", crc_out, 0);
    check(in_ready == 1'b1, "R1 ready", in_ready, 1);
  endtask

  task automatic t_encode();
    logic [63:0] g; logic v, ok, av;
    logic [15:0] lf = 16'hACE1;
    for (int p = 0; p < 5; p++) begin
      int len;
      len = (p == 3) ? 1 : 20;
      for (int i = 0; i < len; i++) begin
        case (p)
          0: buf_a[i] = 8'h00;
          1: buf_a[i] = 8'hFF;
          2: buf_a[i] = 8'(i);
          3: buf_a[i] = 8'h80;
          default: begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            buf_a[i] = lf[7:0];
          end
        endcase
      end
      run_msg(0, len, 1'b1, 1'b0, 1'b0, 0, g, v, ok, av);
      check(g == ref_crc(0, len), "R2 encode remainder", g, ref_crc(0, len));
      check(v == 1'b1, "R3 valid after eop", v, 1);
      check(av == 1'b0, "R3 valid one cycle", av, 0);
      check(ok == 1'b0, "R7 ok low in encode", ok, 0);
    end
  endtask

  task automatic t_check();
    logic [63:0] g; logic v, ok, av;
    for (int i = 0; i < 24; i++) buf_a[i] = 8'(i * 37 + 5);
    append_crc(24);
    run_msg(0, 32, 1'b1, 1'b1, 1'b1, 0, g, v, ok, av);
    check(ok == 1'b1 && v == 1'b1, "R5 intact codeword passes", {v, ok}, 2'b11);
    check(g == 0, "R5 zero remainder", g, 0);
    // R6 single bit flip in the appended remainder
    buf_a[27] = buf_a[27] ^ 8'h10;
    run_msg(0, 32, 1'b1, 1'b1, 1'b1, 0, g, v, ok, av);
    check(ok == 1'b0 && v == 1'b1, "R6 one flipped bit", ok, 0);
    buf_a[27] = buf_a[27] ^ 8'h10;
    // R6 three flipped bits spread over the message
    buf_a[0] ^= 8'h01; buf_a[9] ^= 8'h40; buf_a[30] ^= 8'h02;
    run_msg(0, 32, 1'b1, 1'b1, 1'b1, 0, g, v, ok, av);
    check(ok == 1'b0, "R6 three flipped bits", ok, 0);
    buf_a[0] ^= 8'h01; buf_a[9] ^= 8'h40; buf_a[30] ^= 8'h02;
    // R10 mode taken from the last byte only
    run_msg(0, 32, 1'b1, 1'b1, 1'b0, 0, g, v, ok, av);
    check(ok == 1'b0 && v == 1'b1, "R10 encode on last byte", ok, 0);
    run_msg(0, 32, 1'b1, 1'b0, 1'b1, 0, g, v, ok, av);
    check(ok == 1'b1, "R10 check on last byte", ok, 1);
  endtask

  task automatic t_back_to_back();
    logic [63:0] expa, expb;
    for (int i = 0; i < 7; i++) buf_a[i] = 8'hC3 ^ 8'(i * 11);
    expa = ref_crc(0, 3); expb = ref_crc(3, 4);
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      if (i == 3) begin
        check(crc_valid == 1'b1, "R4 first message done", crc_valid, 1);
        check(crc_out == expa, "R4 first remainder", crc_out, expa);
      end
      if (i == 2) check(crc_valid == 1'b0, "R3 no early valid", crc_valid, 0);
      in_valid = 1'b1; in_data = buf_a[i]; in_check = 1'b0;
      in_sop = (i == 0) || (i == 3); in_eop = (i == 2) || (i == 6);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    check(crc_valid == 1'b1 && crc_out == expb, "R4 second remainder", crc_out, expb);
  endtask

  task automatic t_gaps();
    logic [63:0] g; logic v, ok, av;
    for (int i = 0; i < 10; i++) buf_a[i] = 8'(i * 29 + 1);
    run_msg(0, 10, 1'b1, 1'b0, 1'b0, 3, g, v, ok, av);
    check(g == ref_crc(0, 10), "R9 gaps keep remainder", g, ref_crc(0, 10));
    check(hold_err == 1'b0, "R9 register held in gaps", hold_err, 0);
  endtask

  task automatic t_clear();
    logic [63:0] g; logic v, ok, av;
    for (int i = 0; i < 10; i++) buf_a[i] = 8'(i * 71 + 9);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = buf_a[i]; in_sop = (i == 0); in_eop = 1'b0; in_check = 1'b0;
    end
    @(negedge clk);
    clr = 1'b1; in_valid = 1'b1; in_data = 8'h55; in_sop = 1'b0; in_eop = 1'b1;
    #1 check(in_ready == 1'b0, "R8 ready low in clear", in_ready, 0);
    @(negedge clk);
    clr = 1'b0; in_valid = 1'b0; in_eop = 1'b0;
    check(crc_out == 0, "R8 cleared register", crc_out, 0);
    check(crc_valid == 1'b0, "R8 byte during clear ignored", crc_valid, 0);
    run_msg(5, 5, 1'b0, 1'b0, 1'b0, 0, g, v, ok, av);
    check(g == ref_crc(5, 5), "R8 resume from zero", g, ref_crc(5, 5));
  endtask

  initial begin
    t_reset();
    t_encode();
    t_check();
    t_back_to_back();
    t_gaps();
    t_clear();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule